// File: doc/BRIEF.md
# Serial DAC Command Interface

This block is the digital front end of a serial-input digital-to-analog converter. A host drives three wires into it: an active-low frame strobe, a serial clock and a serial data line. The block oversamples all three with its own system clock and collects one command word per frame. It then drives the converter core with a DAC code, a 2-bit output-stage mode and a single-cycle strobe that marks each executed command.

A build parameter picks the word format. The wide format uses a 24-bit word that holds a 16-bit code. The narrow format uses a 16-bit word that holds a 14-bit code. A frame is executed when its last bit arrives, even if the strobe stays low after that. A frame whose strobe returns high early is discarded. A word of all ones restores the power-on defaults. The system clock must run at least four times faster than the serial clock.

Top module: `sdac_front`

## Requirements
- R1: A frame begins only on a high-to-low transition of `sync_n`. Bits are taken on falling edges of `sclk`, most significant first. While `sync_n` stays high, the serial clock and data have no effect.
- R2: In the wide format (`WIDE`=1, 24-bit word), bits [17:16] are the mode and bits [15:0] are the code. Bits [23:18] are ignored unless the word is all ones.
- R3: In the narrow format (`WIDE`=0, 16-bit word), bits [15:14] are the mode and bits [13:0] are the code. The command executes on the 16th falling edge.
- R4: The command executes on the final falling edge of the frame, whether `sync_n` then rises or stays low. Every executed command raises `upd_stb` for exactly one system clock cycle.
- R5: If `sync_n` rises before the final falling edge, the frame is discarded: code, mode and strobe are unaffected. The next frame is decoded from its first bit.
- R6: After a frame completes, further `sclk` falling edges are ignored until `sync_n` goes high and then low again.
- R7: Mode encoding: 00 normal, 01 output open, 10 output to ground through 100 kΩ, 11 output to ground through 1 kΩ. A frame with mode 00 loads both code and mode. A frame with a non-zero mode changes only the mode, so the stored code is kept through power-down.
- R8: In the narrow format, mode 11 is reserved. Such a frame (other than all ones) is ignored, with no change and no strobe.
- R9: While reset is asserted and until the first valid frame, the mode is 00. The code is zero, or mid-scale (only the MSB set) when `RESET_MID`=1.
- R10: A frame of all ones (every bit of the word, including the upper bits) restores the R9 defaults for both code and mode and raises `upd_stb` once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_n | input | 1 | Active-low frame strobe, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous, data taken on falling edge |
| sdin | input | 1 | Serial data, MSB first |
| dac_code | output | DW (16 wide, 14 narrow) | Current code for the converter core |
| pd_mode | output | 2 | Output-stage mode (R7 encoding) |
| upd_stb | output | 1 | One-cycle pulse per executed command |

## Verification
A table of complete wide frames covers several cases, and each one separates a different fault. Codes around the major carry and the two extremes expose bit-order and field-position errors. Words with non-zero upper bits show that the reserved field is really ignored. Frames that select each power-down mode show whether the code is wrongly overwritten. Directed frames cut short after a few bits and one bit short of complete separate abort handling from completion. Frames carrying extra clocks separate "execute on the last edge" from "execute on strobe rise". A narrow instance built with mid-scale reset covers the 14-bit layout, the reserved mode and the software reset to a non-zero default.

// File: rtl/sdac_pkg.sv
// Shared types for the serial DAC command interface.
package sdac_pkg;

    // Output-stage mode carried in each command word
    typedef enum logic [1:0] {
        PD_NORMAL = 2'b00,
        PD_OPEN   = 2'b01,
        PD_R100K  = 2'b10,
        PD_R1K    = 2'b11
    } pd_mode_e;

    // Frame collector states
    typedef enum logic [1:0] {
        FR_IDLE  = 2'b00,
        FR_SHIFT = 2'b01,
        FR_DONE  = 2'b10
    } frame_st_e;

endpackage

// File: rtl/sdac_sync.sv
// sdac_sync: multi-stage synchronizer for asynchronous single-bit inputs.
// Assumes each input is stable for several system clocks between changes.
// RST_VAL gives the idle level each bit takes during reset.
module sdac_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    // Shift the raw inputs through the synchronizer stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/sdac_frame.sv
// sdac_frame: detects strobe and clock edges in the system clock domain and
// assembles one FW-bit command word per frame. Completes on the FW-th
// falling clock edge; an early strobe rise discards the frame; after
// completion it waits for the strobe to go high before re-arming.
// Assumes synchronized inputs.
module sdac_frame
    import sdac_pkg::*;
#(
    parameter int FW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fs_s,
    input  logic          sck_s,
    input  logic          sd_s,
    output logic          cmd_vld,
    output logic [FW-1:0] cmd_word
);

    localparam int CW = $clog2(FW);

    frame_st_e      st;
    logic [CW-1:0]  cnt;
    logic [FW-2:0]  sh;
    logic           fs_d, sck_d;
    logic           fs_fall, fs_rise, sck_fall, last_bit;

    // Previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_d  <= 1'b1;
            sck_d <= 1'b1;
        end else begin
            fs_d  <= fs_s;
            sck_d <= sck_s;
        end
    end

    // Edge decode of the synchronized strobe and clock
    always_comb begin
        fs_fall  = fs_d & ~fs_s;
        fs_rise  = ~fs_d & fs_s;
        sck_fall = sck_d & ~sck_s;
        last_bit = (cnt == CW'(FW - 1));
    end

    // Frame state machine, bit counter and shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= FR_IDLE;
            cnt      <= '0;
            sh       <= '0;
            cmd_vld  <= 1'b0;
            cmd_word <= '0;
        end else begin
            cmd_vld <= 1'b0;
            case (st)
                FR_IDLE: begin
                    if (fs_fall) begin
                        st  <= FR_SHIFT;
                        cnt <= '0;
                        sh  <= '0;
                    end
                end
                FR_SHIFT: begin
                    if (sck_fall && last_bit) begin
                        cmd_vld  <= 1'b1;
                        cmd_word <= {sh, sd_s};
                        sh       <= '0;
                        cnt      <= '0;
                        st       <= FR_DONE;
                    end else if (fs_rise) begin
                        sh  <= '0;
                        cnt <= '0;
                        st  <= FR_IDLE;
                    end else if (sck_fall) begin
                        sh  <= {sh[FW-3:0], sd_s};
                        cnt <= cnt + 1'b1;
                    end
                end
                FR_DONE: begin
                    if (fs_s) st <= FR_IDLE;
                end
                default: st <= FR_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sdac_regs.sv
// sdac_regs: executes decoded command words. It holds the code and mode
// registers, applies the all-ones software reset and rejects the reserved
// mode of the narrow format. Pulses upd for one cycle per executed command.
module sdac_regs
    import sdac_pkg::*;
#(
    parameter int FW        = 24,
    parameter int DW        = 16,
    parameter bit WIDE      = 1'b1,
    parameter bit RESET_MID = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_vld,
    input  logic [FW-1:0] cmd_word,
    output logic [DW-1:0] code,
    output logic [1:0]    mode,
    output logic          upd
);

    localparam logic [DW-1:0] CODE_DEF = RESET_MID ? {1'b1, {(DW-1){1'b0}}} : '0;

    pd_mode_e      mode_f;
    logic [DW-1:0] code_f;
    logic          sw_rst, reserved;

    // Field split and command classification
    always_comb begin
        mode_f   = pd_mode_e'(cmd_word[DW+1:DW]);
        code_f   = cmd_word[DW-1:0];
        sw_rst   = &cmd_word;
        reserved = !WIDE && (mode_f == PD_R1K);
    end

    // Register update on each executed command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= CODE_DEF;
            mode <= PD_NORMAL;
            upd  <= 1'b0;
        end else begin
            upd <= 1'b0;
            if (cmd_vld) begin
                if (sw_rst) begin
                    code <= CODE_DEF;
                    mode <= PD_NORMAL;
                    upd  <= 1'b1;
                end else if (!reserved) begin
                    mode <= mode_f;
                    if (mode_f == PD_NORMAL) code <= code_f;
                    upd  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sdac_front.sv
// sdac_front: top of the serial DAC command interface. Synchronizes the
// three serial wires, assembles frames and drives code, mode and update
// strobe. WIDE selects a 24-bit word with 16-bit code, or a 16-bit word
// with 14-bit code. Assumes clk runs at least 4x the serial clock.
module sdac_front #(
    parameter bit WIDE      = 1'b1,
    parameter bit RESET_MID = 1'b0,
    parameter int SYNC_STG  = 2,
    localparam int DW       = WIDE ? 16 : 14,
    localparam int FW       = WIDE ? 24 : 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_n,
    input  logic          sclk,
    input  logic          sdin,
    output logic [DW-1:0] dac_code,
    output logic [1:0]    pd_mode,
    output logic          upd_stb
);

    logic [2:0]    raw, syn;
    logic          cmd_vld;
    logic [FW-1:0] cmd_word;

    assign raw = {sync_n, sclk, sdin};

    sdac_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b110)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (syn)
    );

    sdac_frame #(.FW(FW)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .fs_s     (syn[2]),
        .sck_s    (syn[1]),
        .sd_s     (syn[0]),
        .cmd_vld  (cmd_vld),
        .cmd_word (cmd_word)
    );

    sdac_regs #(.FW(FW), .DW(DW), .WIDE(WIDE), .RESET_MID(RESET_MID)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_vld  (cmd_vld),
        .cmd_word (cmd_word),
        .code     (dac_code),
        .mode     (pd_mode),
        .upd      (upd_stb)
    );

endmodule

// File: rtl/sdac_front_chk.sv
// sdac_front_chk: temporal checks on the command interface outputs,
// attached to every sdac_front instance by the bind below.
module sdac_front_chk #(
    parameter int DW   = 16,
    parameter bit WIDE = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_vld,
    input logic [DW-1:0] dac_code,
    input logic [1:0]    pd_mode,
    input logic          upd_stb
);

    // R4: strobe lasts a single cycle
    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> !upd_stb);

    // R5: outputs only move together with the strobe
    assert_hold_without_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_stb |-> ($stable(dac_code) && $stable(pd_mode)));

    // R4: every strobe follows a completed frame
    assert_strobe_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |-> $past(cmd_vld));

    // R7: entering a power-down mode keeps the code
    assert_pd_keeps_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && pd_mode != 2'b00) |-> (dac_code == $past(dac_code)));

    // R8: the reserved mode never appears in the narrow format
    assert_no_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!WIDE && upd_stb) |-> (pd_mode != 2'b11));

endmodule

bind sdac_front sdac_front_chk #(.DW(DW), .WIDE(WIDE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_vld  (cmd_vld),
    .dac_code (dac_code),
    .pd_mode  (pd_mode),
    .upd_stb  (upd_stb)
);

// File: tb/sim_sdac_front.sv
module sim_sdac_front;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic fs = 1'b1, sck = 1'b1, sd = 1'b0, tgt = 1'b0;
    logic fs0, sck0, fs1, sck1;
    assign fs0  = tgt ? 1'b1 : fs;
    assign sck0 = tgt ? 1'b1 : sck;
    assign fs1  = tgt ? fs  : 1'b1;
    assign sck1 = tgt ? sck : 1'b1;

    logic [15:0] code0;
    logic [13:0] code1;
    logic [1:0]  mode0, mode1;
    logic        upd0, upd1;

    sdac_front #(.WIDE(1'b1), .RESET_MID(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_n(fs0), .sclk(sck0), .sdin(sd),
        .dac_code(code0), .pd_mode(mode0), .upd_stb(upd0));

    sdac_front #(.WIDE(1'b0), .RESET_MID(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .sync_n(fs1), .sclk(sck1), .sdin(sd),
        .dac_code(code1), .pd_mode(mode1), .upd_stb(upd1));

    int n0 = 0, n1 = 0, tests = 0, fails = 0;
    bit done = 1'b0;

    // strobe counters
    always @(posedge clk) begin
        if (upd0) n0++;
        if (upd1) n1++;
    end

    task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", r, got, exp);
        end
    endtask

    // one frame: nb word bits MSB first, 'clocked' falling edges (extra are ones)
    task automatic send(input logic to1, input logic [23:0] w, input int nb, input int clocked);
        tgt = to1;
        #20;
        fs = 1'b0;
        #80;
        for (int i = 0; i < clocked; i++) begin
            sck = 1'b1;
            sd  = (i < nb) ? w[nb-1-i] : 1'b1;
            #40;
            sck = 1'b0;
            #40;
        end
        sck = 1'b1;
        #40;
        fs = 1'b1;
        sd = 1'b0;
        #200;
        @(negedge clk);
    endtask

    // {word, expected code, expected mode}
    localparam logic [41:0] VEC [10] = '{
        {24'h00ABCD, 16'hABCD, 2'd0},
        {24'h001234, 16'h1234, 2'd0},
        {24'h01FFFF, 16'h1234, 2'd1},
        {24'h020000, 16'h1234, 2'd2},
        {24'h035555, 16'h1234, 2'd3},
        {24'hFC8001, 16'h8001, 2'd0},
        {24'h00FFFF, 16'hFFFF, 2'd0},
        {24'h000000, 16'h0000, 2'd0},
        {24'h007FFF, 16'h7FFF, 2'd0},
        {24'h008000, 16'h8000, 2'd0}
    };

    initial begin
        repeat (4) @(negedge clk);
        chk("R9 reset code wide", 32'(code0), 32'h0);
        chk("R9 reset mode wide", 32'(mode0), 32'h0);
        chk("R9 reset code narrow mid", 32'(code1), 32'h2000);
        chk("R9 no strobe in reset", 32'(n0 + n1), 32'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // table: R1 R2 R4 R7
        for (int k = 0; k < 10; k++) begin
            send(1'b0, VEC[k][41:18], 24, 24);
            chk("R1/R2 code", 32'(code0), 32'(VEC[k][17:2]));
            chk("R7 mode", 32'(mode0), 32'(VEC[k][1:0]));
            chk("R4 strobe count", 32'(n0), 32'(k + 1));
        end

        // R5: abort one bit short, then early
        send(1'b0, 24'h001111, 24, 23);
        chk("R5 late abort code", 32'(code0), 32'h8000);
        chk("R5 late abort strobe", 32'(n0), 32'd10);
        send(1'b0, 24'h03FFFF, 24, 5);
        chk("R5 early abort mode", 32'(mode0), 32'h0);
        send(1'b0, 24'h002222, 24, 24);
        chk("R5 recovery code", 32'(code0), 32'h2222);
        chk("R5 recovery strobe", 32'(n0), 32'd11);

        // R6 / R4: extra clocks while sync low
        send(1'b0, 24'h003333, 24, 32);
        chk("R6 extra clocks code", 32'(code0), 32'h3333);
        chk("R4 single exec", 32'(n0), 32'd12);

        // R10: software reset from power-down
        send(1'b0, 24'h020000, 24, 24);
        chk("R7 pd keeps code", 32'(code0), 32'h3333);
        send(1'b0, 24'hFFFFFF, 24, 24);
        chk("R10 swreset code", 32'(code0), 32'h0);
        chk("R10 swreset mode", 32'(mode0), 32'h0);
        chk("R10 swreset strobe", 32'(n0), 32'd14);

        // narrow instance
        send(1'b1, 24'h001ABC, 16, 16);
        chk("R3 narrow code", 32'(code1), 32'h1ABC);
        chk("R3 narrow strobe", 32'(n1), 32'd1);
        chk("R1 idle wide untouched", 32'(n0), 32'd14);
        send(1'b1, 24'h008000, 16, 16);
        chk("R7 narrow pd mode", 32'(mode1), 32'h2);
        chk("R7 narrow pd code", 32'(code1), 32'h1ABC);
        send(1'b1, 24'h00C123, 16, 16);
        chk("R8 reserved mode", 32'(mode1), 32'h2);
        chk("R8 reserved code", 32'(code1), 32'h1ABC);
        chk("R8 reserved no strobe", 32'(n1), 32'd2);
        send(1'b1, 24'h000555, 16, 24);
        chk("R3/R6 narrow 16th edge", 32'(code1), 32'h0555);
        chk("R3 narrow mode", 32'(mode1), 32'h0);
        send(1'b1, 24'h00FFFF, 16, 16);
        chk("R10/R9 narrow swreset mid", 32'(code1), 32'h2000);
        chk("R10 narrow strobe", 32'(n1), 32'd4);
        send(1'b1, 24'h000777, 16, 15);
        chk("R5 narrow abort", 32'(code1), 32'h2000);
        chk("R5 narrow abort strobe", 32'(n1), 32'd4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // watchdog
    initial begin
        #1000000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule